// File: doc/BRIEF.md
# Indirect-Addressed NVRAM Access Port

This block lets a host on a byte-wide synchronous I/O bus reach an 8 KB byte-addressable store without a direct memory window. The host first loads a 13-bit memory address in two pieces, writing an 8-bit low part and a 5-bit high part to two separate strobe registers. It then reads or writes a single data-window register, which moves one byte to or from the location those registers point at.

The usual software sequence is low strobe, then high strobe, then one data-window access. The latched address survives data-window traffic, so a run of data accesses keeps hitting the same byte until a strobe register is written again. The backing store is an internal 8192-byte array, so the block can be tested on its own.

Top module: `nvram_window_port`

## Requirements
- R1: The store holds 8192 bytes addressed by a 13-bit address `{high[4:0], low[7:0]}`. A byte written through the data window at any address, including 0x0000 and 0x1FFF, reads back unchanged.
- R2: A host write to offset 0x74 loads the written byte into address bits 7..0.
- R3: A host write to offset 0x75 loads written bits 4..0 into address bits 12..8. Written bits 7..5 have no effect on the address.
- R4: A host write to offset 0x77 stores the byte at the latched address. A host read of offset 0x77 returns the byte stored there.
- R5: Every offset other than 0x74, 0x75 and 0x77, including 0x76, is unmapped. Writes to it change neither the address nor the store, and reads of it return 0xFF.
- R6: A read of 0x74 returns the latched low address byte. A read of 0x75 returns `{3'b000, high[4:0]}`.
- R7: Data-window reads and writes leave the latched address unchanged, so repeated data-window accesses all hit the same byte.
- R8: Read data appears on `io_rdata` after the clock edge that accepts the read strobe. The previous value is still present during the strobe cycle, and the new value is held until the next accepted read.
- R9: A synchronous active-high reset clears both address parts to zero and sets `io_rdata` to 0xFF. It leaves the store contents intact.
- R10: Only one access is taken per clock. When the read and write strobes are both high, the block performs the write only and `io_rdata` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 8 | Host I/O offset |
| io_wdata | input | 8 | Host write byte |
| io_wr | input | 1 | Write strobe, one access per high cycle |
| io_rd | input | 1 | Read strobe, one access per high cycle |
| io_rdata | output | 8 | Registered read byte |

## Verification
Two functions can fall in the same clock: a host write and a host read. The bench provokes the overlap by raising both strobes on the data-window offset while `io_rdata` holds a known, different byte. It judges the result in two steps. First, `io_rdata` must be unchanged after that edge. Second, a later plain data-window read must return the byte that was written. A second overlap is also exercised: a data-window write followed in the very next cycle by a read of the same byte, which must return the new value.

// File: rtl/nvw_pkg.sv
package nvw_pkg;

  typedef enum logic [1:0] {
    SEL_LO   = 2'd0,
    SEL_HI   = 2'd1,
    SEL_DATA = 2'd2,
    SEL_NONE = 2'd3
  } nvw_sel_e;

  // Maps a host offset to the register it selects.
  function automatic nvw_sel_e nvw_decode(input int unsigned off,
                                          input int unsigned lo_off,
                                          input int unsigned hi_off,
                                          input int unsigned dat_off);
    if (off == lo_off)       return SEL_LO;
    else if (off == hi_off)  return SEL_HI;
    else if (off == dat_off) return SEL_DATA;
    else                     return SEL_NONE;
  endfunction

endpackage

// File: rtl/nvw_strobe_regs.sv
module nvw_strobe_regs #(
  parameter int DATA_W = 8,
  parameter int HI_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] lo_q,
  output logic [HI_W-1:0]   hi_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (ld_lo) lo_q <= wdata;
      if (ld_hi) hi_q <= wdata[HI_W-1:0];
    end
  end

endmodule

// File: rtl/nvw_byte_store.sv
module nvw_byte_store #(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata_q
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // No reset: the contents must survive a block reset.
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata_q <= mem[addr];
  end

endmodule

// File: rtl/nvw_read_path.sv
module nvw_read_path
  import nvw_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int HI_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_acc,
  input  nvw_sel_e          sel,
  input  logic [DATA_W-1:0] lo_q,
  input  logic [HI_W-1:0]   hi_q,
  input  logic [DATA_W-1:0] mem_q,
  output logic [DATA_W-1:0] rdata
);

  localparam int PAD_W = DATA_W - HI_W;

  nvw_sel_e          sel_q;
  logic [DATA_W-1:0] lo_snap;
  logic [HI_W-1:0]   hi_snap;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= SEL_NONE;
      lo_snap <= '0;
      hi_snap <= '0;
    end else if (rd_acc) begin
      sel_q   <= sel;
      lo_snap <= lo_q;
      hi_snap <= hi_q;
    end
  end

  always_comb begin
    unique case (sel_q)
      SEL_LO:   rdata = lo_snap;
      SEL_HI:   rdata = {{PAD_W{1'b0}}, hi_snap};
      SEL_DATA: rdata = mem_q;
      default:  rdata = '1;
    endcase
  end

endmodule

// File: rtl/nvram_window_port.sv
module nvram_window_port
  import nvw_pkg::*;
#(
  parameter int IO_AW   = 8,
  parameter int DATA_W  = 8,
  parameter int MEM_AW  = 13,
  parameter int LO_OFF  = 'h74,
  parameter int HI_OFF  = 'h75,
  parameter int DAT_OFF = 'h77
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic [DATA_W-1:0] io_rdata
);

  localparam int HI_W = MEM_AW - DATA_W;

  // Named internal events, also observed by the checker.
  nvw_sel_e          sel;
  logic              wr_acc, rd_acc;
  logic              ld_lo, ld_hi, mem_we, mem_re;
  logic [DATA_W-1:0] lo_q, mem_q;
  logic [HI_W-1:0]   hi_q;
  logic [MEM_AW-1:0] lat_addr;

  assign sel      = nvw_decode(32'(io_addr), LO_OFF, HI_OFF, DAT_OFF);
  assign wr_acc   = io_wr;
  assign rd_acc   = io_rd & ~io_wr;
  assign ld_lo    = wr_acc && (sel == SEL_LO);
  assign ld_hi    = wr_acc && (sel == SEL_HI);
  assign mem_we   = wr_acc && (sel == SEL_DATA);
  assign mem_re   = rd_acc && (sel == SEL_DATA);
  assign lat_addr = {hi_q, lo_q};

  nvw_strobe_regs #(.DATA_W(DATA_W), .HI_W(HI_W)) u_strobe (
    .clk(clk), .rst(rst), .ld_lo(ld_lo), .ld_hi(ld_hi),
    .wdata(io_wdata), .lo_q(lo_q), .hi_q(hi_q)
  );

  nvw_byte_store #(.AW(MEM_AW), .DW(DATA_W)) u_store (
    .clk(clk), .we(mem_we), .re(mem_re), .addr(lat_addr),
    .wdata(io_wdata), .rdata_q(mem_q)
  );

  nvw_read_path #(.DATA_W(DATA_W), .HI_W(HI_W)) u_rdpath (
    .clk(clk), .rst(rst), .rd_acc(rd_acc), .sel(sel),
    .lo_q(lo_q), .hi_q(hi_q), .mem_q(mem_q), .rdata(io_rdata)
  );

endmodule

// File: rtl/nvw_checker.sv
module nvw_checker #(
  parameter int IO_AW   = 8,
  parameter int DATA_W  = 8,
  parameter int MEM_AW  = 13,
  parameter int LO_OFF  = 'h74,
  parameter int HI_OFF  = 'h75,
  parameter int DAT_OFF = 'h77
) (
  input logic              clk,
  input logic              rst,
  input logic [IO_AW-1:0]  io_addr,
  input logic [DATA_W-1:0] io_wdata,
  input logic              io_wr,
  input logic              io_rd,
  input logic [DATA_W-1:0] io_rdata,
  input logic [MEM_AW-1:0] lat_addr
);

  localparam int HI_W  = MEM_AW - DATA_W;
  localparam int PAD_W = DATA_W - HI_W;

  logic is_lo, is_hi, is_dat, is_none;
  assign is_lo   = (32'(io_addr) == LO_OFF);
  assign is_hi   = (32'(io_addr) == HI_OFF);
  assign is_dat  = (32'(io_addr) == DAT_OFF);
  assign is_none = !is_lo && !is_hi && !is_dat;

  p_lo_latch_r2: assert property (@(posedge clk) disable iff (rst)
    (io_wr && is_lo) |=> (lat_addr[DATA_W-1:0] == $past(io_wdata)));

  p_hi_latch_r3: assert property (@(posedge clk) disable iff (rst)
    (io_wr && is_hi) |=> (lat_addr[MEM_AW-1:DATA_W] == $past(io_wdata[HI_W-1:0])));

  // R5 and R7: only strobe writes may move the address.
  p_addr_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !(io_wr && (is_lo || is_hi)) |=> $stable(lat_addr));

  p_unmapped_read_r5: assert property (@(posedge clk) disable iff (rst)
    (io_rd && !io_wr && is_none) |=> (io_rdata == '1));

  p_hi_pad_r6: assert property (@(posedge clk) disable iff (rst)
    (io_rd && !io_wr && is_hi) |=> (io_rdata[DATA_W-1:HI_W] == {PAD_W{1'b0}}));

  p_rdata_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !(io_rd && !io_wr) |=> $stable(io_rdata));

  p_both_strobes_r10: assert property (@(posedge clk) disable iff (rst)
    (io_rd && io_wr) |=> $stable(io_rdata));

  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (lat_addr == '0 && io_rdata == '1));

endmodule

bind nvram_window_port nvw_checker #(
  .IO_AW(IO_AW), .DATA_W(DATA_W), .MEM_AW(MEM_AW),
  .LO_OFF(LO_OFF), .HI_OFF(HI_OFF), .DAT_OFF(DAT_OFF)
) u_chk (
  .clk(clk), .rst(rst), .io_addr(io_addr), .io_wdata(io_wdata),
  .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .lat_addr(lat_addr)
);

// File: tb/sim_nvram_window_port.sv
`timescale 1ns/1ps
module sim_nvram_window_port;

  localparam logic [7:0] A_LO = 8'h74, A_HI = 8'h75, A_GAP = 8'h76, A_DAT = 8'h77;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] io_addr = '0, io_wdata = '0, io_rdata;
  logic       io_wr = 1'b0, io_rd = 1'b0;
  int         n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  nvram_window_port u0 (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata)
  );

  // Test pattern for the sweep, restated independently of the design.
  function automatic logic [7:0] pat(input int a);
    return 8'((a * 7) ^ (a >> 8) ^ 8'h5A);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  // Each access takes one clock: drive at a falling edge, release at the next.
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    io_addr = a; io_wdata = d; io_wr = 1'b1; io_rd = 1'b0;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    io_addr = a; io_rd = 1'b1; io_wr = 1'b0;
    @(negedge clk);
    io_rd = 1'b0;
    d = io_rdata;
  endtask

  task automatic set_addr(input int a);
    wr(A_LO, 8'(a));
    wr(A_HI, 8'(a >> 8));
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R9 rdata after reset", io_rdata, 8'hFF);
    rd(A_LO, d); chk("R9 low cleared", d, 8'h00);
    rd(A_HI, d); chk("R9 high cleared", d, 8'h00);
  endtask

  task automatic t_strobes();
    logic [7:0] d;
    wr(A_LO, 8'hC3); rd(A_LO, d); chk("R2 low strobe", d, 8'hC3);
    wr(A_HI, 8'hF6); rd(A_HI, d); chk("R3 R6 high strobe masked", d, 8'h16);
    rd(A_LO, d); chk("R6 low unchanged by high write", d, 8'hC3);
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    set_addr(16'h0ABC);
    wr(A_DAT, 8'h3C);
    wr(A_GAP, 8'h11); wr(8'h00, 8'h22); wr(8'hFF, 8'h33);
    rd(A_GAP, d); chk("R5 read 0x76", d, 8'hFF);
    rd(8'h10, d); chk("R5 read other offset", d, 8'hFF);
    rd(A_LO, d);  chk("R5 low unaffected", d, 8'hBC);
    rd(A_HI, d);  chk("R5 high unaffected", d, 8'h0A);
    rd(A_DAT, d); chk("R5 store unaffected", d, 8'h3C);
  endtask

  task automatic t_repeat();
    logic [7:0] d;
    set_addr(16'h0123);
    wr(A_DAT, 8'h01); wr(A_DAT, 8'h02);
    rd(A_DAT, d); chk("R7 second write same byte", d, 8'h02);
    rd(A_DAT, d); chk("R7 repeated read", d, 8'h02);
    rd(A_LO, d);  chk("R7 low kept", d, 8'h23);
    rd(A_HI, d);  chk("R7 high kept", d, 8'h01);
    set_addr(16'h0124); wr(A_DAT, 8'h99);
    set_addr(16'h0123); rd(A_DAT, d); chk("R4 neighbour untouched", d, 8'h02);
  endtask

  task automatic t_latency();
    logic [7:0] d;
    set_addr(16'h0042); wr(A_DAT, 8'hA5);
    rd(A_LO, d); chk("R8 prior value", d, 8'h42);
    io_addr = A_DAT; io_rd = 1'b1;
    #1 chk("R8 old data during strobe cycle", io_rdata, 8'h42);
    @(negedge clk); io_rd = 1'b0;
    chk("R8 data one edge later", io_rdata, 8'hA5);
    @(negedge clk); @(negedge clk);
    chk("R8 data held", io_rdata, 8'hA5);
  endtask

  task automatic t_collide();
    logic [7:0] d;
    set_addr(16'h0777); wr(A_DAT, 8'h10);
    rd(A_LO, d);
    io_addr = A_DAT; io_wdata = 8'hE7; io_wr = 1'b1; io_rd = 1'b1;
    @(negedge clk); io_wr = 1'b0; io_rd = 1'b0;
    chk("R10 rdata unchanged on both strobes", io_rdata, 8'h77);
    rd(A_DAT, d); chk("R10 write taken", d, 8'hE7);
    wr(A_DAT, 8'h6D); rd(A_DAT, d); chk("R4 back-to-back write read", d, 8'h6D);
  endtask

  task automatic t_sweep();
    logic [7:0] d;
    int bad = 0;
    for (int a = 0; a < 8192; a++) begin set_addr(a); wr(A_DAT, pat(a)); end
    for (int a = 0; a < 8192; a++) begin
      set_addr(a); rd(A_DAT, d);
      if (d !== pat(a)) bad++;
    end
    chk("R1 sweep mismatches", 8'(bad), 8'h00);
    set_addr(0);       rd(A_DAT, d); chk("R1 address 0x0000", d, pat(0));
    set_addr(16'h1FFF); rd(A_DAT, d); chk("R1 address 0x1FFF", d, pat(8191));
  endtask

  task automatic t_keep_on_reset();
    logic [7:0] d;
    do_reset();
    set_addr(16'h1FFF); rd(A_DAT, d); chk("R9 store survives reset", d, pat(8191));
  endtask

  initial begin
    do_reset();
    t_reset();
    t_strobes();
    t_unmapped();
    t_repeat();
    t_latency();
    t_collide();
    t_sweep();
    t_keep_on_reset();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule